// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank State Tracking

This block watches the command pins of a DDR SDRAM bus and decodes each clock's sample into one command code. For each command it also returns the fields that command carries: the bank, the row for an activation, the column and per-access auto-precharge request for reads and writes. It keeps an open or closed state and the open row for each of the four banks. It raises an illegal flag whenever a command breaks the bus protocol.

Typical uses are as a bus monitor inside a memory-controller subsystem, or as the command front end of a behavioural memory model. All decoded outputs are registered. The decode of a pin sample taken at clock edge N appears right after edge N. Bank state changed by that sample is visible at the same time. An illegal command still reports its decoded code and fields, but it changes no bank state and no burst context.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select high, or with chip select low and RAS, CAS and WE all high, the command code is 0 (no operation) and the illegal flag stays low. The other codes are: activate 1, read 2, write 3, burst stop 4, single-bank precharge 5, all-bank precharge 6, auto refresh 7, self-refresh entry 8, mode register load 9. The pins {cs_n,ras_n,cas_n,we_n} decode as: activate 0011, read 0101, write 0100, burst stop 0110, precharge 0010, refresh 0001, mode load 0000.
- R2: After an activate, cmd_row carries addr and cmd_bank carries ba. cmd_row is zero for every other command.
- R3: An accepted activate opens the addressed bank, and bank_row slice [b*13 +: 13] holds its row.
- R4: For reads and writes, cmd_col[9:0] is addr[9:0]. cmd_col[10] is addr[11] when org_x8 is high and 0 otherwise. cmd_autopre is addr[10]. For other commands, cmd_col and cmd_autopre are zero.
- R5: A precharge with addr[10] low closes only bank ba. With addr[10] high it closes every bank, whatever ba holds.
- R6: Burst stop is legal only when the most recent accepted command other than no-op and activate was a read with addr[10] low. Any other case flags it illegal.
- R7: Reading or writing a closed bank, or activating an open bank, is flagged illegal. Bank state is then left unchanged.
- R8: An accepted read or write with auto-precharge leaves the bank open in the cycle after it is sampled. The bank reads as closed one clock later.
- R9: The refresh encoding decodes as auto refresh when cke is high and as self-refresh entry when cke is low.
- R10: Refresh of either kind, or a mode load, is flagged illegal while any bank is open.
- R11: With cke low, any command other than no-op and self-refresh entry is flagged illegal and has no effect.
- R12: Synchronous active-low reset closes every bank, clears the stored rows, sets the command code to 0 and clears the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row / column / qualifier address |
| org_x8 | input | 1 | Selects x8 column width (adds addr[11]) |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank field of the decoded command |
| cmd_row | output | 13 | Row field (activate only) |
| cmd_col | output | 11 | Column field (read/write only) |
| cmd_autopre | output | 1 | Auto-precharge request of a read/write |
| illegal | output | 1 | Protocol misuse in the decoded command |
| bank_open | output | 4 | Open status, one bit per bank |
| bank_row | output | 52 | Stored open row per bank, 13 bits each |

## Verification
The checker watches the state consequences of accepted commands on every cycle. An accepted activate must leave its bank open. An all-bank precharge must leave none open. An auto-precharge access must close its bank one clock later. Refresh and mode load are accepted only when all banks were idle, and a burst stop only with a live read context. The checker also ties the internal cke and bank-state violation events to the illegal flag in the following cycle. The exact field extraction cannot be shown by a property: the column layout in both organisations, stored rows, selective versus global precharge, and that rejected commands leave the state untouched. The bench's directed scenarios cover these with known expected values.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int unsigned COL_W = 11;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_ACT    = 4'd1,
    CMD_RD     = 4'd2,
    CMD_WR     = 4'd3,
    CMD_BST    = 4'd4,
    CMD_PRE    = 4'd5,
    CMD_PREALL = 4'd6,
    CMD_AREF   = 4'd7,
    CMD_SREF   = 4'd8,
    CMD_MRS    = 4'd9
  } cmd_e;

  // Pin-level decode. The a10 input splits precharge; cke splits refresh.
  function automatic cmd_e pins_to_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n,
                                       input logic a10, input logic cke);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b110:  c = CMD_BST;
        3'b010:  c = a10 ? CMD_PREALL : CMD_PRE;
        3'b001:  c = cke ? CMD_AREF : CMD_SREF;
        default: c = CMD_MRS;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  function automatic logic needs_idle(input cmd_e c);
    return (c == CMD_AREF) || (c == CMD_SREF) || (c == CMD_MRS);
  endfunction

  // Commands that may be issued while the clock enable is low.
  function automatic logic cke_exempt(input cmd_e c);
    return (c == CMD_NOP) || (c == CMD_SREF);
  endfunction

  // Commands that leave the read-burst context untouched.
  function automatic logic keeps_burst(input cmd_e c);
    return (c == CMD_NOP) || (c == CMD_ACT);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [ADDR_W-1:0] addr,
  input  logic              org_x8,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] row,
  output logic [COL_W-1:0]  col,
  output logic              autopre
);

  localparam int unsigned AP_BIT  = 10;
  localparam int unsigned X8_BIT  = 11;
  localparam int unsigned LOW_COL = 10;

  function automatic logic [COL_W-1:0] column_of(input logic [ADDR_W-1:0] a,
                                                 input logic x8);
    logic [COL_W-1:0] v;
    v = '0;
    v[LOW_COL-1:0] = a[LOW_COL-1:0];
    v[COL_W-1]     = x8 & a[X8_BIT];
    return v;
  endfunction

  always_comb begin
    cmd     = pins_to_cmd(cs_n, ras_n, cas_n, we_n, addr[AP_BIT], cke);
    row     = (cmd == CMD_ACT) ? addr : '0;
    col     = is_access(cmd) ? column_of(addr, org_x8) : '0;
    autopre = is_access(cmd) & addr[AP_BIT];
  end

endmodule

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned NBANK = 4
) (
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic             cke,
  input  logic [NBANK-1:0] open_vec,
  input  logic             burst_ok,
  output logic             ev_bad_cke,
  output logic             ev_bad_state,
  output logic             ev_bad_bst,
  output logic             ev_busy,
  output logic             accept
);

  logic tgt_open;

  always_comb begin
    tgt_open     = open_vec[ba];
    ev_bad_cke   = !cke && !cke_exempt(cmd);
    ev_bad_state = (is_access(cmd) && !tgt_open) ||
                   ((cmd == CMD_ACT) && tgt_open);
    ev_bad_bst   = (cmd == CMD_BST) && !burst_ok;
    ev_busy      = needs_idle(cmd) && (|open_vec);
    accept       = !(ev_bad_cke || ev_bad_state || ev_bad_bst || ev_busy);
  end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int unsigned ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_open,
  input  logic             do_close,
  input  logic             do_sched,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= do_sched;
      if (do_open) begin
        is_open <= 1'b1;
        row_q   <= row_in;
      end else if (do_close || pend_q) begin
        is_open <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cs_n,
  input  logic                           ras_n,
  input  logic                           cas_n,
  input  logic                           we_n,
  input  logic                           cke,
  input  logic [BA_W-1:0]                ba,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           org_x8,
  output logic [3:0]                     cmd_code,
  output logic [BA_W-1:0]                cmd_bank,
  output logic [ADDR_W-1:0]              cmd_row,
  output logic [COL_W-1:0]               cmd_col,
  output logic                           cmd_autopre,
  output logic                           illegal,
  output logic [(1<<BA_W)-1:0]           bank_open,
  output logic [(1<<BA_W)*ADDR_W-1:0]    bank_row
);

  localparam int unsigned NBANK = 1 << BA_W;

  cmd_e              dec_cmd;
  logic [ADDR_W-1:0] dec_row;
  logic [COL_W-1:0]  dec_col;
  logic              dec_ap;

  logic ev_bad_cke, ev_bad_state, ev_bad_bst, ev_busy, accept;
  logic burst_ok_q;

  // Named internal events for the checker.
  logic ev_open, ev_close_one, ev_close_all, ev_sched;

  sdram_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .cke     (cke),
    .addr    (addr),
    .org_x8  (org_x8),
    .cmd     (dec_cmd),
    .row     (dec_row),
    .col     (dec_col),
    .autopre (dec_ap)
  );

  sdram_cmd_check #(.BA_W(BA_W), .NBANK(NBANK)) u_chk (
    .cmd          (dec_cmd),
    .ba           (ba),
    .cke          (cke),
    .open_vec     (bank_open),
    .burst_ok     (burst_ok_q),
    .ev_bad_cke   (ev_bad_cke),
    .ev_bad_state (ev_bad_state),
    .ev_bad_bst   (ev_bad_bst),
    .ev_busy      (ev_busy),
    .accept       (accept)
  );

  always_comb begin
    ev_open      = accept && (dec_cmd == CMD_ACT);
    ev_close_one = accept && (dec_cmd == CMD_PRE);
    ev_close_all = accept && (dec_cmd == CMD_PREALL);
    ev_sched     = accept && is_access(dec_cmd) && dec_ap;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));
    sdram_bank_slot #(.ROW_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_open  (ev_open && hit),
      .do_close (ev_close_all || (ev_close_one && hit)),
      .do_sched (ev_sched && hit),
      .row_in   (dec_row),
      .is_open  (bank_open[b]),
      .row_q    (bank_row[b*ADDR_W +: ADDR_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_ok_q <= 1'b0;
    end else if (accept && !keeps_burst(dec_cmd)) begin
      burst_ok_q <= (dec_cmd == CMD_RD) && !dec_ap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code    <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_autopre <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      cmd_code    <= dec_cmd;
      cmd_bank    <= ba;
      cmd_row     <= dec_row;
      cmd_col     <= dec_col;
      cmd_autopre <= dec_ap;
      illegal     <= !accept;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker_sva.sv
module sdram_cmd_tracker_sva
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cmd_code,
  input logic [BA_W-1:0]  cmd_bank,
  input logic             cmd_autopre,
  input logic             illegal,
  input logic [NBANK-1:0] bank_open,
  input logic             burst_ok_q,
  input logic             ev_bad_cke,
  input logic             ev_bad_state
);

  logic acc_rdwr;
  assign acc_rdwr = !illegal && (cmd_code == CMD_RD || cmd_code == CMD_WR);

  assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_NOP) |-> !illegal);

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT && !illegal) |-> bank_open[cmd_bank]);

  assert_preall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PREALL && !illegal) |-> (bank_open == '0));

  assert_bst_context_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_BST && !illegal) |-> $past(burst_ok_q));

  assert_access_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdwr |-> ((($past(bank_open) >> cmd_bank) & NBANK'(1)) != '0));

  assert_state_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_state |=> illegal);

  assert_ap_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdwr && cmd_autopre) |=> !bank_open[$past(cmd_bank)]);

  assert_idle_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal && (cmd_code == CMD_AREF || cmd_code == CMD_SREF ||
                  cmd_code == CMD_MRS)) |-> ($past(bank_open) == '0));

  assert_cke_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_cke |=> illegal);

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_sva #(.BA_W(BA_W), .NBANK(1 << BA_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_code     (cmd_code),
  .cmd_bank     (cmd_bank),
  .cmd_autopre  (cmd_autopre),
  .illegal      (illegal),
  .bank_open    (bank_open),
  .burst_ok_q   (burst_ok_q),
  .ev_bad_cke   (ev_bad_cke),
  .ev_bad_state (ev_bad_state)
);

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_BST = 4,
                 C_PRE = 5, C_PREALL = 6, C_AREF = 7, C_SREF = 8, C_MRS = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        org_x8 = 1'b0;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [10:0] cmd_col;
  logic        cmd_autopre, illegal;
  logic [3:0]  bank_open;
  logic [51:0] bank_row;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .org_x8(org_x8),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .illegal(illegal),
    .bank_open(bank_open), .bank_row(bank_row)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one pin sample, let the design take it, sample after the edge.
  task automatic send(input logic [3:0] pins, input logic k,
                      input logic [1:0] b, input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n} = pins;
    cke  = k;
    ba   = b;
    addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();            send(4'b0111, 1'b1, 2'd0, 13'd0); endtask
  task automatic act(input logic [1:0] b, input logic [12:0] r);
    send(4'b0011, 1'b1, b, r);
  endtask
  task automatic rd(input logic [1:0] b, input logic [12:0] a);
    send(4'b0101, 1'b1, b, a);
  endtask
  task automatic wr(input logic [1:0] b, input logic [12:0] a);
    send(4'b0100, 1'b1, b, a);
  endtask
  task automatic bst();            send(4'b0110, 1'b1, 2'd0, 13'd0); endtask
  task automatic pre(input logic [1:0] b, input logic all);
    send(4'b0010, 1'b1, b, all ? 13'h0400 : 13'h0000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R12", "code at reset", cmd_code, C_NOP);
    check("R12", "illegal at reset", illegal, 0);
    check("R12", "banks at reset", bank_open, 4'b0000);
    rst_n = 1'b1;
  endtask

  task automatic t_nop();
    send(4'b1000, 1'b1, 2'd3, 13'h1FFF);   // deselect with other pins active
    check("R1", "deselect code", cmd_code, C_NOP);
    check("R1", "deselect illegal", illegal, 0);
    nop();
    check("R1", "nop code", cmd_code, C_NOP);
    check("R1", "nop illegal", illegal, 0);
  endtask

  task automatic t_activate();
    act(2'd2, 13'h1ABC);
    check("R2", "act code", cmd_code, C_ACT);
    check("R2", "act row", cmd_row, 13'h1ABC);
    check("R2", "act bank", cmd_bank, 2'd2);
    check("R3", "bank open", bank_open, 4'b0100);
    check("R3", "stored row", bank_row[2*13 +: 13], 13'h1ABC);
    act(2'd2, 13'h0123);
    check("R7", "act on open bank flagged", illegal, 1);
    check("R7", "row kept", bank_row[2*13 +: 13], 13'h1ABC);
    nop();
    check("R7", "open set kept", bank_open, 4'b0100);
  endtask

  task automatic t_fields();
    rd(2'd0, 13'h0010);
    check("R7", "read closed bank flagged", illegal, 1);
    nop();
    check("R7", "closed bank untouched", bank_open, 4'b0100);
    org_x8 = 1'b0;
    rd(2'd2, 13'h0A55);
    check("R4", "read code", cmd_code, C_RD);
    check("R4", "x16 column", cmd_col, 11'h255);
    check("R4", "no autopre", cmd_autopre, 0);
    check("R2", "row zero on read", cmd_row, 13'h0000);
    org_x8 = 1'b1;
    wr(2'd2, 13'h0A55);
    check("R4", "write code", cmd_code, C_WR);
    check("R4", "x8 column", cmd_col, 11'h655);
    check("R4", "write legal", illegal, 0);
    org_x8 = 1'b0;
  endtask

  task automatic t_burst_stop();
    rd(2'd2, 13'h0004);
    bst();
    check("R6", "bst after plain read", illegal, 0);
    check("R6", "bst code", cmd_code, C_BST);
    bst();
    check("R6", "second bst flagged", illegal, 1);
    rd(2'd2, 13'h0004);
    act(2'd1, 13'h0007);                   // activate keeps read context
    bst();
    check("R6", "bst after read+act", illegal, 0);
    wr(2'd2, 13'h0008);
    bst();
    check("R6", "bst after write flagged", illegal, 1);
    pre(2'd1, 1'b0);
    check("R5", "bank1 closed", bank_open, 4'b0100);
  endtask

  task automatic t_autopre();
    rd(2'd2, 13'h0404);
    check("R4", "autopre flag", cmd_autopre, 1);
    check("R8", "still open next cycle", bank_open, 4'b0100);
    bst();
    check("R6", "bst after read-ap flagged", illegal, 1);
    check("R8", "closed one clock later", bank_open, 4'b0000);
  endtask

  task automatic t_precharge();
    act(2'd1, 13'h0011);
    act(2'd3, 13'h0033);
    check("R3", "two banks open", bank_open, 4'b1010);
    pre(2'd1, 1'b0);
    check("R5", "precharge code", cmd_code, C_PRE);
    check("R5", "only bank1 closed", bank_open, 4'b1000);
    pre(2'd1, 1'b1);                       // ba names closed bank1; all close
    check("R5", "precharge-all code", cmd_code, C_PREALL);
    check("R5", "all banks closed", bank_open, 4'b0000);
  endtask

  task automatic t_refresh_mrs();
    act(2'd0, 13'h0100);
    send(4'b0001, 1'b1, 2'd0, 13'd0);
    check("R10", "refresh with open bank", illegal, 1);
    send(4'b0000, 1'b1, 2'd0, 13'h0032);
    check("R10", "mode load with open bank", illegal, 1);
    pre(2'd0, 1'b0);
    send(4'b0001, 1'b1, 2'd0, 13'd0);
    check("R9", "auto refresh code", cmd_code, C_AREF);
    check("R10", "refresh idle legal", illegal, 0);
    send(4'b0000, 1'b1, 2'd0, 13'h0032);
    check("R9", "mode load code", cmd_code, C_MRS);
    check("R10", "mode load idle legal", illegal, 0);
    send(4'b0001, 1'b0, 2'd0, 13'd0);
    check("R9", "self refresh code", cmd_code, C_SREF);
    check("R11", "self refresh legal", illegal, 0);
  endtask

  task automatic t_cke_low();
    send(4'b0111, 1'b0, 2'd0, 13'd0);
    check("R11", "nop with cke low", illegal, 0);
    send(4'b0011, 1'b0, 2'd1, 13'h0055);
    check("R11", "act with cke low flagged", illegal, 1);
    nop();
    check("R11", "bank stays closed", bank_open, 4'b0000);
    check("R11", "row not stored", bank_row[1*13 +: 13], 13'h0011);
  endtask

  task automatic t_reset_mid();
    act(2'd3, 13'h1234);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R12", "banks closed by reset", bank_open, 4'b0000);
    check("R12", "code nop after reset", cmd_code, C_NOP);
    check("R12", "row cleared", bank_row[3*13 +: 13], 13'h0000);
    rst_n = 1'b1;
    nop();
  endtask

  initial begin
    t_reset();
    t_nop();
    t_activate();
    t_fields();
    t_burst_stop();
    t_autopre();
    t_precharge();
    t_refresh_mrs();
    t_cke_low();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule